// File: doc/BRIEF.md
# Confidence-Based Fetch Gating Controller

This block decides when instruction fetch should pause because too many weakly predicted branches are still unresolved. It takes per-cycle strobes from the pipeline and keeps a saturating count of low-confidence branches in flight. The decode stage strobes when it sees a branch marked low-confidence. The execute/writeback stage strobes when such a branch resolves, whether it was predicted correctly or not. A pipeline flush removes a given number of squashed low-confidence branches at once.

The count is compared against a threshold that software can write. The block drives a registered stall to the fetch unit while the count is above that threshold. Only fetch is held. Instructions already fetched keep moving, and branches that resolve during a stall still lower the count, so the stall releases on its own. The live count is also available as a status output.

Top module: `fetch_gate_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, `lc_count` is 0 and `fetch_stall` is 0. The threshold starts at the parameter `THR_RST` (default 2).
- R2: A cycle with `dec_lowconf`=1, `res_lowconf`=0 and `flush_valid`=0 raises `lc_count` by one, visible in the next cycle.
- R3: A cycle with `res_lowconf`=1, `dec_lowconf`=0 and `flush_valid`=0 lowers `lc_count` by one, visible in the next cycle.
- R4: A cycle with both `dec_lowconf` and `res_lowconf` at 1 and no flush leaves `lc_count` unchanged.
- R5: `lc_count` saturates at 2^CNT_W-1 (15 by default). A further increment leaves it at that value.
- R6: A resolve strobe while `lc_count` is 0 leaves it at 0.
- R7: A cycle with `flush_valid`=1 sets `lc_count` to `lc_count - flush_cnt`, or to 0 when `flush_cnt` is greater than or equal to the count. `dec_lowconf` and `res_lowconf` are ignored in a flush cycle.
- R8: `fetch_stall` is 1 in the cycle after any cycle in which `lc_count` is strictly greater than the threshold. A count equal to the threshold gives no stall.
- R9: `fetch_stall` returns to 0 in the cycle after `lc_count` falls to or below the threshold.
- R10: A cycle with `thr_wr_en`=1 loads `thr_wr_data` into the threshold. The stall comparison uses the new value from the following cycle, so the stall output reflects it one cycle after that.
- R11: Strobes are counted normally while `fetch_stall` is 1. The stall changes nothing except the `fetch_stall` output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dec_lowconf | input | 1 | A low-confidence branch entered decode this cycle |
| res_lowconf | input | 1 | A counted branch resolved at execute/writeback this cycle |
| flush_valid | input | 1 | A pipeline flush happens this cycle |
| flush_cnt | input | CNT_W | Number of low-confidence branches squashed by the flush |
| thr_wr_en | input | 1 | Write strobe for the threshold |
| thr_wr_data | input | CNT_W | New threshold value |
| fetch_stall | output | 1 | Registered request to hold instruction fetch |
| lc_count | output | CNT_W | Current count of unresolved low-confidence branches |

## Verification
If the stored count drifts, for example through a missed saturation, a wrap below zero, or a simultaneous increment and decrement that is not cancelled, the wrong value shows on `lc_count` in the very next cycle. The same fault reaches `fetch_stall` one cycle later, as a stall that starts or ends at the wrong time. A threshold that is held wrongly shows only through `fetch_stall`, two cycles after the write. The bench therefore checks both outputs after every cycle against an independent model. It also moves the count across the threshold in both directions and takes it to its top and bottom limits.

// File: rtl/fgc_pkg.sv
package fgc_pkg;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_INC   = 2'd1,
    OP_DEC   = 2'd2,
    OP_FLUSH = 2'd3
  } cnt_op_e;

endpackage

// File: rtl/fgc_rst_sync.sv
module fgc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[i] <= 1'b0;
          else        sync_q[i] <= 1'b1;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[i] <= 1'b0;
          else        sync_q[i] <= sync_q[i-1];
        end
      end
    end
  endgenerate

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/fgc_thresh_reg.sv
module fgc_thresh_reg #(
  parameter int W       = 4,
  parameter int RST_VAL = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] thr
);

  logic [W-1:0] thr_q;
  logic [W-1:0] thr_d;

  always_comb begin
    thr_d = thr_q;
    if (wr_en) thr_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     thr_q <= W'(RST_VAL);
    else if (wr_en) thr_q <= thr_d;
  end

  assign thr = thr_q;

endmodule

// File: rtl/fgc_counter.sv
module fgc_counter
  import fgc_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  cnt_op_e      op,
  input  logic [W-1:0] flush_amt,
  output logic [W-1:0] cnt
);

  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_d = cnt_q;
    unique case (op)
      OP_INC:   if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
      OP_DEC:   if (cnt_q != '0)      cnt_d = cnt_q - 1'b1;
      OP_FLUSH: cnt_d = (flush_amt >= cnt_q) ? '0 : (cnt_q - flush_amt);
      default:  cnt_d = cnt_q;
    endcase
  end

  assign cnt_en = (op != OP_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/fgc_stall_gen.sv
module fgc_stall_gen #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] thr,
  output logic         stall
);

  logic stall_q;
  logic stall_d;
  logic stall_en;

  always_comb begin
    stall_d  = (cnt > thr);
    stall_en = (stall_d != stall_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        stall_q <= 1'b0;
    else if (stall_en) stall_q <= stall_d;
  end

  assign stall = stall_q;

endmodule

// File: rtl/fetch_gate_ctrl.sv
module fetch_gate_ctrl
  import fgc_pkg::*;
#(
  parameter int CNT_W       = 4,
  parameter int THR_RST     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dec_lowconf,
  input  logic             res_lowconf,
  input  logic             flush_valid,
  input  logic [CNT_W-1:0] flush_cnt,
  input  logic             thr_wr_en,
  input  logic [CNT_W-1:0] thr_wr_data,
  output logic             fetch_stall,
  output logic [CNT_W-1:0] lc_count
);

  logic             rst_sync_n;
  logic [CNT_W-1:0] thr_val;
  logic [CNT_W-1:0] cnt_val;
  cnt_op_e          cnt_op;

  fgc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // Flush wins over everything; a matched inc/dec pair cancels.
  always_comb begin
    if (flush_valid)                     cnt_op = OP_FLUSH;
    else if (dec_lowconf && !res_lowconf) cnt_op = OP_INC;
    else if (res_lowconf && !dec_lowconf) cnt_op = OP_DEC;
    else                                 cnt_op = OP_HOLD;
  end

  fgc_thresh_reg #(.W(CNT_W), .RST_VAL(THR_RST)) u_thr (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (thr_wr_en),
    .wr_data (thr_wr_data),
    .thr     (thr_val)
  );

  fgc_counter #(.W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .op        (cnt_op),
    .flush_amt (flush_cnt),
    .cnt       (cnt_val)
  );

  fgc_stall_gen #(.W(CNT_W)) u_stall (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .cnt   (cnt_val),
    .thr   (thr_val),
    .stall (fetch_stall)
  );

  assign lc_count = cnt_val;

endmodule

// File: rtl/fetch_gate_ctrl_chk.sv
module fetch_gate_ctrl_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             dec_lowconf,
  input logic             res_lowconf,
  input logic             flush_valid,
  input logic [CNT_W-1:0] flush_cnt,
  input logic [CNT_W-1:0] thr_val,
  input logic [CNT_W-1:0] lc_count,
  input logic             fetch_stall
);

  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (dec_lowconf && !res_lowconf && !flush_valid && lc_count != MAXV) |=> (lc_count == $past(lc_count) + 1'b1)); // R2

  AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (res_lowconf && !dec_lowconf && !flush_valid && lc_count != '0) |=> (lc_count == $past(lc_count) - 1'b1)); // R3

  AST_PAIR_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (dec_lowconf && res_lowconf && !flush_valid) |=> $stable(lc_count)); // R4

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (lc_count == MAXV && !flush_valid && !res_lowconf) |=> (lc_count == MAXV)); // R5

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (lc_count == '0 && !flush_valid && !dec_lowconf) |=> (lc_count == '0)); // R6

  AST_FLUSH_CLAMP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (flush_valid && flush_cnt >= lc_count) |=> (lc_count == '0)); // R7

  AST_STALL_ON: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (lc_count > thr_val) |=> fetch_stall); // R8

  AST_STALL_OFF: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (lc_count <= thr_val) |=> !fetch_stall); // R9

endmodule

bind fetch_gate_ctrl fetch_gate_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .dec_lowconf (dec_lowconf),
  .res_lowconf (res_lowconf),
  .flush_valid (flush_valid),
  .flush_cnt   (flush_cnt),
  .thr_val     (thr_val),
  .lc_count    (lc_count),
  .fetch_stall (fetch_stall)
);

// File: tb/fetch_gate_ctrl_bench.sv
`timescale 1ns/1ps
module fetch_gate_ctrl_bench;

  localparam int W = 4;
  localparam int MAXV = (1 << W) - 1;

  logic         clk;
  logic         rst_n;
  logic         dec_lowconf, res_lowconf, flush_valid, thr_wr_en;
  logic [W-1:0] flush_cnt, thr_wr_data;
  logic         fetch_stall;
  logic [W-1:0] lc_count;

  typedef struct {
    int    cnt;
    bit    stall;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_vec  = 0;
  int   n_fail = 0;
  int   m_cnt  = 0;
  int   m_thr  = 2;
  bit   m_stall = 1'b0;

  fetch_gate_ctrl u_fetch_gate_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .dec_lowconf (dec_lowconf),
    .res_lowconf (res_lowconf),
    .flush_valid (flush_valid),
    .flush_cnt   (flush_cnt),
    .thr_wr_en   (thr_wr_en),
    .thr_wr_data (thr_wr_data),
    .fetch_stall (fetch_stall),
    .lc_count    (lc_count)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input int cnt_exp, input bit st_exp, input string tag);
    n_vec++;
    if (int'(lc_count) != cnt_exp || fetch_stall !== st_exp) begin
      n_fail++;
      $display("FAIL %s: count=%0d stall=%0b expected count=%0d stall=%0b",
               tag, lc_count, fetch_stall, cnt_exp, st_exp);
    end
  endtask

  // Driver: apply one cycle of stimulus and push the model's prediction.
  task automatic step(input bit d, input bit r, input bit f, input int fc,
                      input bit w, input int wd, input string tag);
    int   nc;
    exp_t e;
    @(negedge clk);
    dec_lowconf = d; res_lowconf = r; flush_valid = f;
    flush_cnt = W'(fc); thr_wr_en = w; thr_wr_data = W'(wd);
    if (f)           nc = (fc >= m_cnt) ? 0 : m_cnt - fc;
    else if (d && !r) nc = (m_cnt == MAXV) ? MAXV : m_cnt + 1;
    else if (r && !d) nc = (m_cnt == 0) ? 0 : m_cnt - 1;
    else             nc = m_cnt;
    m_stall = (m_cnt > m_thr);
    if (w) m_thr = wd;
    m_cnt = nc;
    e.cnt = m_cnt; e.stall = m_stall; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // Monitor: compare the prediction shortly after the edge it refers to.
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.cnt, e.stall, e.tag);
      end
    end
  end

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] lfsr;
    dec_lowconf = 0; res_lowconf = 0; flush_valid = 0; thr_wr_en = 0;
    flush_cnt = '0; thr_wr_data = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #5 check(0, 1'b0, "R1 in reset");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #5 check(0, 1'b0, "R1 after release");

    step(1,0,0,0,0,0, "R2 inc");
    step(1,0,0,0,0,0, "R2 inc");
    step(0,0,0,0,0,0, "R8 equal to threshold no stall");
    step(1,0,0,0,0,0, "R2 inc above threshold");
    step(0,0,0,0,0,0, "R8 stall rises");
    step(1,0,0,0,0,0, "R11 counting during stall");
    step(1,1,0,0,0,0, "R4 pair holds");
    step(0,1,0,0,0,0, "R3 dec");
    step(0,1,0,0,0,0, "R3 dec to threshold");
    step(0,0,0,0,0,0, "R9 stall falls");
    step(0,1,0,0,0,0, "R3 dec");
    step(0,1,0,0,0,0, "R3 dec to zero");
    step(0,1,0,0,0,0, "R6 no underflow");
    step(1,1,0,0,0,0, "R4 pair at zero");
    for (int i = 0; i < 18; i++) step(1,0,0,0,0,0, "R5 saturate");
    step(0,0,0,0,0,0, "R5 held at max");
    step(1,1,1,5,0,0, "R7 flush partial ignores strobes");
    step(0,0,1,15,0,0, "R7 flush clamps at zero");
    step(1,0,1,3,0,0, "R7 flush from zero");
    step(1,0,0,0,1,0, "R10 threshold write zero");
    step(0,0,0,0,0,0, "R10 new threshold seen");
    step(0,0,0,0,0,0, "R10 stall from new threshold");
    step(0,0,0,0,1,15, "R10 threshold write max");
    step(1,0,0,0,0,0, "R10 stall drops");
    step(0,0,0,0,0,0, "R10 stall low");

    lfsr = 8'hA5;
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step(lfsr[0], lfsr[1], (lfsr[7:4] == 4'hF), int'(lfsr[5:2]),
           (lfsr[7:3] == 5'h0A), int'(lfsr[3:0]), "R7 R11 mixed");
    end
    step(0,0,0,0,0,0, "R9 idle");
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule